// File: doc/BRIEF.md
# Scanline-Timed Interrupt Burst Generator

This block raises a burst of interrupt events at points tied to video scanlines. A host arms it with a repeat count, a cycle offset inside a line (x) and a line number (y). The first event lands one whole frame after the most recent frame-start pulse, plus y line periods (computed as y times the frame length divided by the line count), plus x clock cycles. Every later event follows exactly one line period after the previous scheduled point, until the count is used up. Each event sets a sticky interrupt-status bit. The host clears the bit by writing zero to it.

Two timing standards are supported. The 60 Hz standard has 263 lines per frame and the 50 Hz standard has 314. The mode input picks one of them, and the block captures it when the host arms. All periods are derived from the clock-rate parameter by integer division when the design is elaborated. The frame-start pulse comes from an external video timing generator. The other interrupt sources and the mask logic sit outside this block.

Top module: `scanline_irq_gen`

## Requirements
- R1: After reset the status output is 0, no event is pending, and the internal cycle counter starts from 0 at the first clock edge after reset is released.
- R2: With F = floor(CLK_HZ/60) and L = 263 when pal_mode_i = 0, or F = floor(CLK_HZ/50) and L = 314 when pal_mode_i = 1, the first event occurs in the cycle whose counter value equals B + F + floor(y·F/L) + x. Here B is the counter value captured by the latest frame-start pulse.
- R3: Each subsequent event of a burst occurs exactly P = floor(F/L) cycles after the previous scheduled event. The interval is timed from the schedule and does not depend on when the status bit was serviced.
- R4: An armed count n ≥ 2 yields exactly n events. A count of 0 or 1 yields exactly one event. No event follows the last one.
- R5: The status bit stays set until it is cleared. An acknowledge write whose bit value is 1 has no effect.
- R6: An acknowledge write whose bit value is 0 clears the status bit at the next edge.
- R7: If an event and a clearing acknowledge fall in the same cycle, the status bit ends up set.
- R8: Arming while a burst is pending or in progress discards the old schedule and count. Only the new burst's events occur.
- R9: If arm_i and frame_start_i are asserted in the same cycle, B is that cycle's counter value.
- R10: The timing mode is sampled when arm_i is asserted. Changing pal_mode_i during a burst does not alter the burst's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle pulse marking the start of a video frame |
| pal_mode_i | input | 1 | 0: 60 Hz / 263 lines, 1: 50 Hz / 314 lines |
| arm_i | input | 1 | Arm a new burst using the fields below |
| arm_count_i | input | CNT_W | Number of events in the burst |
| arm_x_i | input | X_W | Cycle offset added to the first event |
| arm_y_i | input | Y_W | Line offset of the first event |
| ack_wr_i | input | 1 | Write strobe for the status bit |
| ack_bit_i | input | 1 | Value written to the status bit; 0 clears it |
| irq_stat_o | output | 1 | Sticky interrupt-status bit |

## Verification
The setting of the status bit by a scheduled event and its clearing by a host acknowledge can land on the same edge. The bench provokes this in a two-event burst. It leaves the first event unacknowledged, then drives a clearing write in exactly the cycle of the second scheduled event. It judges the case correct if the bit is still set after that edge and is cleared by a later write. A second collision is also provoked: an arm coinciding with a frame-start pulse. That case is judged by the exact arrival cycle of the first event.

// File: rtl/slirq_pkg.sv
package slirq_pkg;

  typedef enum logic [1:0] {SCH_IDLE, SCH_DIV, SCH_WAIT} sch_state_e;

  localparam int unsigned LINES_60 = 263;
  localparam int unsigned LINES_50 = 314;

  function automatic int unsigned frame_len(int unsigned clk_hz, bit pal);
    return pal ? clk_hz / 50 : clk_hz / 60;
  endfunction

  function automatic int unsigned line_count(bit pal);
    return pal ? LINES_50 : LINES_60;
  endfunction

  function automatic int unsigned line_len(int unsigned clk_hz, bit pal);
    return frame_len(clk_hz, pal) / line_count(pal);
  endfunction

endpackage

// File: rtl/slirq_timebase.sv
module slirq_timebase #(
  parameter int unsigned TIME_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  output logic [TIME_W-1:0] cyc_o,
  output logic [TIME_W-1:0] base_o
);

  logic [TIME_W-1:0] cyc_q, fs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      fs_q  <= '0;
    end else begin
      cyc_q <= cyc_q + TIME_W'(1);
      if (frame_start_i) fs_q <= cyc_q;
    end
  end

  assign cyc_o  = cyc_q;
  // a pulse in the arming cycle defines the frame base directly
  assign base_o = frame_start_i ? cyc_q : fs_q;

endmodule

// File: rtl/slirq_div.sv
module slirq_div #(
  parameter int unsigned DD_W = 33,
  parameter int unsigned DV_W = 9,
  parameter int unsigned Q_W  = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [DD_W-1:0] dividend_i,
  input  logic [DV_W-1:0] divisor_i,
  output logic            done_o,
  output logic [Q_W-1:0]  quo_o
);

  localparam int unsigned CW = $clog2(DD_W + 1);

  logic [DD_W-1:0] quo_q;
  logic [DV_W-1:0] rem_q, dv_q, rem_nx;
  logic [DV_W:0]   rem_sh;
  logic [CW-1:0]   cnt_q;
  logic            busy_q, done_q, ge;

  always_comb begin
    rem_sh = {rem_q, quo_q[DD_W-1]};
    ge     = rem_sh >= {1'b0, dv_q};
    rem_nx = ge ? (rem_sh[DV_W-1:0] - dv_q) : rem_sh[DV_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dv_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      quo_q  <= dividend_i;
      rem_q  <= '0;
      dv_q   <= divisor_i;
      cnt_q  <= CW'(DD_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      quo_q <= {quo_q[DD_W-2:0], ge};
      rem_q <= rem_nx;
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q[Q_W-1:0];

endmodule

// File: rtl/slirq_sched.sv
module slirq_sched
  import slirq_pkg::*;
#(
  parameter int unsigned CLK_HZ = 157800,
  parameter int unsigned TIME_W = 24,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned X_W    = 12,
  parameter int unsigned Y_W    = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              pal_mode_i,
  input  logic [CNT_W-1:0]  arm_count_i,
  input  logic [X_W-1:0]    arm_x_i,
  input  logic [Y_W-1:0]    arm_y_i,
  input  logic [TIME_W-1:0] base_i,
  input  logic [TIME_W-1:0] cyc_i,
  output logic              evt_o,
  output sch_state_e        st_o,
  output logic [TIME_W-1:0] target_o,
  output logic [TIME_W-1:0] line_o,
  output logic [CNT_W-1:0]  cnt_o
);

  localparam int unsigned PW   = Y_W + TIME_W;
  localparam int unsigned DV_W = $clog2(LINES_50 + 1);
  localparam logic [TIME_W-1:0] FRAME_60 = TIME_W'(frame_len(CLK_HZ, 1'b0));
  localparam logic [TIME_W-1:0] FRAME_50 = TIME_W'(frame_len(CLK_HZ, 1'b1));
  localparam logic [TIME_W-1:0] LINE_60  = TIME_W'(line_len(CLK_HZ, 1'b0));
  localparam logic [TIME_W-1:0] LINE_50  = TIME_W'(line_len(CLK_HZ, 1'b1));
  localparam logic [DV_W-1:0]   NL_60    = DV_W'(LINES_60);
  localparam logic [DV_W-1:0]   NL_50    = DV_W'(LINES_50);

  sch_state_e        st_q;
  logic [TIME_W-1:0] base_q, target_q, frame_sel, line_sel, arm_frame, quo;
  logic [X_W-1:0]    x_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              mode_q, div_done, evt;
  logic [PW-1:0]     dividend;
  logic [DV_W-1:0]   divisor;

  assign arm_frame = pal_mode_i ? FRAME_50 : FRAME_60;
  assign dividend  = PW'(arm_y_i) * PW'(arm_frame);
  assign divisor   = pal_mode_i ? NL_50 : NL_60;
  assign frame_sel = mode_q ? FRAME_50 : FRAME_60;
  assign line_sel  = mode_q ? LINE_50 : LINE_60;

  slirq_div #(.DD_W(PW), .DV_W(DV_W), .Q_W(TIME_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (arm_i),
    .dividend_i (dividend),
    .divisor_i  (divisor),
    .done_o     (div_done),
    .quo_o      (quo)
  );

  assign evt = (st_q == SCH_WAIT) && (cyc_i == target_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= SCH_IDLE;
      base_q   <= '0;
      target_q <= '0;
      x_q      <= '0;
      cnt_q    <= '0;
      mode_q   <= 1'b0;
    end else if (arm_i) begin
      st_q   <= SCH_DIV;
      base_q <= base_i;
      x_q    <= arm_x_i;
      cnt_q  <= arm_count_i;
      mode_q <= pal_mode_i;
    end else begin
      unique case (st_q)
        SCH_DIV: if (div_done) begin
          target_q <= base_q + frame_sel + quo + TIME_W'(x_q);
          st_q     <= SCH_WAIT;
        end
        SCH_WAIT: if (evt) begin
          if (cnt_q <= CNT_W'(1)) begin
            st_q <= SCH_IDLE;
          end else begin
            cnt_q    <= cnt_q - CNT_W'(1);
            target_q <= target_q + line_sel;
          end
        end
        default: ;
      endcase
    end
  end

  assign evt_o    = evt;
  assign st_o     = st_q;
  assign target_o = target_q;
  assign line_o   = line_sel;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/slirq_stat.sv
module slirq_stat (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic ack_wr_i,
  input  logic ack_bit_i,
  output logic stat_o
);

  logic stat_q;

  // a set from an event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      stat_q <= 1'b0;
    else if (evt_i)                   stat_q <= 1'b1;
    else if (ack_wr_i && !ack_bit_i)  stat_q <= 1'b0;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen
  import slirq_pkg::*;
#(
  parameter int unsigned CLK_HZ = 157800,
  parameter int unsigned TIME_W = 24,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned X_W    = 12,
  parameter int unsigned Y_W    = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             pal_mode_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] arm_count_i,
  input  logic [X_W-1:0]   arm_x_i,
  input  logic [Y_W-1:0]   arm_y_i,
  input  logic             ack_wr_i,
  input  logic             ack_bit_i,
  output logic             irq_stat_o
);

  logic [TIME_W-1:0] cyc, base, target, line;
  logic [CNT_W-1:0]  cnt;
  logic              evt;
  sch_state_e        sch_st;

  slirq_timebase #(.TIME_W(TIME_W)) u_tb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .cyc_o         (cyc),
    .base_o        (base)
  );

  slirq_sched #(
    .CLK_HZ(CLK_HZ), .TIME_W(TIME_W), .CNT_W(CNT_W), .X_W(X_W), .Y_W(Y_W)
  ) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm_i),
    .pal_mode_i  (pal_mode_i),
    .arm_count_i (arm_count_i),
    .arm_x_i     (arm_x_i),
    .arm_y_i     (arm_y_i),
    .base_i      (base),
    .cyc_i       (cyc),
    .evt_o       (evt),
    .st_o        (sch_st),
    .target_o    (target),
    .line_o      (line),
    .cnt_o       (cnt)
  );

  slirq_stat u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .ack_wr_i  (ack_wr_i),
    .ack_bit_i (ack_bit_i),
    .stat_o    (irq_stat_o)
  );

endmodule

// File: rtl/slirq_chk.sv
module slirq_chk
  import slirq_pkg::*;
#(
  parameter int unsigned TIME_W = 24,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arm_i,
  input logic              ack_wr_i,
  input logic              ack_bit_i,
  input logic              irq_stat_o,
  input logic              evt_i,
  input sch_state_e        st_i,
  input logic [TIME_W-1:0] target_i,
  input logic [TIME_W-1:0] cyc_i,
  input logic [TIME_W-1:0] line_i,
  input logic [CNT_W-1:0]  cnt_i
);

  logic [TIME_W-1:0] lead;
  assign lead = target_i - cyc_i;

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_stat_o) |-> $past(evt_i));

  p_future_target_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == SCH_WAIT && $past(st_i) == SCH_DIV) |-> (lead != '0 && !lead[TIME_W-1]));

  p_line_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !arm_i && cnt_i > CNT_W'(1)) |=>
      (st_i == SCH_WAIT && target_i == $past(target_i) + $past(line_i)));

  p_burst_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !arm_i && cnt_i <= CNT_W'(1)) |=> st_i == SCH_IDLE);

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_stat_o && !(ack_wr_i && !ack_bit_i)) |=> irq_stat_o);

  p_ack_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_wr_i && !ack_bit_i && !evt_i) |=> !irq_stat_o);

  p_evt_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> irq_stat_o);

  p_rearm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> st_i == SCH_DIV);

endmodule

bind scanline_irq_gen slirq_chk #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arm_i      (arm_i),
  .ack_wr_i   (ack_wr_i),
  .ack_bit_i  (ack_bit_i),
  .irq_stat_o (irq_stat_o),
  .evt_i      (evt),
  .st_i       (sch_st),
  .target_i   (target),
  .cyc_i      (cyc),
  .line_i     (line),
  .cnt_i      (cnt)
);

// File: tb/scanline_irq_gen_tb.sv
`timescale 1ns/1ps
module scanline_irq_gen_tb;

  localparam int CLK_HZ = 157800;
  localparam int TIME_W = 24;
  localparam int CNT_W  = 8;
  localparam int X_W    = 12;
  localparam int Y_W    = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, pal_mode = 1'b0, arm = 1'b0;
  logic [CNT_W-1:0] arm_count = '0;
  logic [X_W-1:0]   arm_x = '0;
  logic [Y_W-1:0]   arm_y = '0;
  logic ack_wr = 1'b0, ack_bit = 1'b0;
  logic irq_stat;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  longint tcnt;
  longint fs_b = 0;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= 0; else tcnt <= tcnt + 1;

  scanline_irq_gen #(
    .CLK_HZ(CLK_HZ), .TIME_W(TIME_W), .CNT_W(CNT_W), .X_W(X_W), .Y_W(Y_W)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start), .pal_mode_i(pal_mode),
    .arm_i(arm), .arm_count_i(arm_count), .arm_x_i(arm_x), .arm_y_i(arm_y),
    .ack_wr_i(ack_wr), .ack_bit_i(ack_bit), .irq_stat_o(irq_stat)
  );

  function automatic longint frm(bit pal);  return pal ? CLK_HZ / 50 : CLK_HZ / 60; endfunction
  function automatic longint nlin(bit pal); return pal ? 314 : 263; endfunction
  function automatic longint per(bit pal);  return frm(pal) / nlin(pal); endfunction
  function automatic longint first_t(longint b, longint x, longint y, bit pal);
    return b + frm(pal) + (y * frm(pal)) / nlin(pal) + x;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1'b1;
    fs_b = tcnt;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic do_arm(int cnt, int x, int y, bit pal, bit with_frame, output longint t0);
    @(negedge clk);
    if (with_frame) begin
      frame_start = 1'b1;
      fs_b = tcnt;
    end
    arm = 1'b1;
    arm_count = CNT_W'(cnt);
    arm_x = X_W'(x);
    arm_y = Y_W'(y);
    pal_mode = pal;
    t0 = first_t(fs_b, x, y, pal);
    @(negedge clk);
    arm = 1'b0;
    frame_start = 1'b0;
  endtask

  task automatic wait_evt(longint exp, output bit seen);
    seen = 0;
    while (!seen && tcnt < exp + 64) begin
      @(negedge clk);
      if (irq_stat) seen = 1;
    end
  endtask

  task automatic clear_ack();
    ack_wr = 1'b1;
    ack_bit = 1'b0;
    @(negedge clk);
    ack_wr = 1'b0;
  endtask

  task automatic run_burst(int n, longint t0, longint p, string req);
    bit seen, extra;
    for (int i = 0; i < n; i++) begin
      longint exp = t0 + i * p + 1;
      wait_evt(exp, seen);
      check(seen && tcnt == exp, req, $sformatf("event %0d arrival", i), seen ? tcnt : -1, exp);
      if (seen) begin
        clear_ack();
        if (i == 0) check(!irq_stat, "R6", "cleared by ack 0", irq_stat, 0);
      end
    end
    extra = 0;
    for (int k = 0; k < 3 * p + 8; k++) begin
      @(negedge clk);
      if (irq_stat) extra = 1;
    end
    check(!extra, "R4", "no event after burst", extra, 0);
    if (extra) clear_ack();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    longint t0, ta, tb;
    bit seen;
    int unsigned seed;
    seed = $urandom(32'd20240611);

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!irq_stat, "R1", "status in reset", irq_stat, 0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    check(!irq_stat, "R1", "status idle after reset", irq_stat, 0);
    check(tcnt == 50, "R1", "cycle count origin", tcnt, 50);

    // R2: 60 Hz single event, no offsets
    pulse_frame();
    do_arm(1, 0, 0, 1'b0, 1'b0, t0);
    run_burst(1, t0, per(0), "R2");

    // R4: count 0 still fires once
    pulse_frame();
    do_arm(0, 3, 2, 1'b0, 1'b0, t0);
    run_burst(1, t0, per(0), "R4");

    // R3: repeats one line apart
    pulse_frame();
    repeat (5) @(negedge clk);
    do_arm(5, 7, 100, 1'b0, 1'b0, t0);
    run_burst(5, t0, per(0), "R3");

    // R10: 50 Hz, last line, mode input flipped during burst
    pulse_frame();
    do_arm(3, 123, 313, 1'b1, 1'b0, t0);
    pal_mode = 1'b0;
    run_burst(3, t0, per(1), "R10");

    // R9: arm coinciding with frame start
    pulse_frame();
    repeat (40) @(negedge clk);
    do_arm(2, 11, 9, 1'b0, 1'b1, t0);
    run_burst(2, t0, per(0), "R9");

    // R8: re-arm replaces pending burst
    pulse_frame();
    do_arm(3, 0, 5, 1'b0, 1'b0, ta);
    repeat (100) @(negedge clk);
    do_arm(2, 40, 20, 1'b0, 1'b0, tb);
    run_burst(2, tb, per(0), "R8");

    // R5/R7: sticky bit, ack of 1, ack colliding with event
    pulse_frame();
    do_arm(2, 5, 3, 1'b0, 1'b0, t0);
    wait_evt(t0 + 1, seen);
    check(seen && tcnt == t0 + 1, "R2", "first event arrival", seen ? tcnt : -1, t0 + 1);
    ack_wr = 1'b1;
    ack_bit = 1'b1;
    @(negedge clk);
    ack_wr = 1'b0;
    check(irq_stat, "R5", "ack of 1 ignored", irq_stat, 1);
    while (tcnt < t0 + per(0)) @(negedge clk);
    ack_wr = 1'b1;
    ack_bit = 1'b0;
    @(negedge clk);
    ack_wr = 1'b0;
    check(irq_stat && tcnt == t0 + per(0) + 1, "R7", "event beats clear", irq_stat, 1);
    repeat (4) @(negedge clk);
    check(irq_stat, "R5", "bit held without ack", irq_stat, 0 + 1);
    clear_ack();
    check(!irq_stat, "R6", "clear after collision", irq_stat, 0);
    run_burst(0, t0, per(0), "R4");

    // random bursts
    for (int r = 0; r < 10; r++) begin
      int cnt = $urandom_range(0, 6);
      int x = $urandom_range(0, 500);
      bit pal = 1'($urandom_range(0, 1));
      int y = $urandom_range(0, pal ? 313 : 262);
      bit wf = 1'($urandom_range(0, 1));
      pulse_frame();
      repeat ($urandom_range(0, 20)) @(negedge clk);
      do_arm(cnt, x, y, pal, wf, t0);
      if ($urandom_range(0, 1) == 1) pal_mode = ~pal_mode;
      run_burst(cnt < 1 ? 1 : cnt, t0, per(pal), "R2");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule